// File: doc/BRIEF.md
# Threshold-Driven Audio FIFO Requester

This block is a word FIFO placed between a DMA-style memory port and a serial audio shifter. In transmit, the DMA side fills the FIFO and the shifter drains it one word at a time. In receive, the shifter fills the FIFO and the DMA side drains it. A single request line tells the DMA engine when to move data.

The request line is not a simple "not full" or "not empty" level. Software sets a burst length for each direction. Each threshold field holds the burst length minus one, so a value of 7 asks for bursts of 8 words. In per-element mode the burst length is always one word, whatever the threshold holds. In threshold mode the burst length is the threshold plus one.

The request arms only when a whole burst fits in the free space (transmit) or is waiting in the FIFO (receive). It then stays high until exactly that many DMA beats have been accepted. On the next cycle it is evaluated again. Sticky flags record a shifter pop from an empty FIFO and a shifter push into a full one.

Top module: `audFifoReq`

## Requirements
- R1: A synchronous active-high reset empties the FIFO, drops the request line and clears both sticky flags.
- R2: Words leave in the order they entered. With `dirRx`=0 the DMA port writes and the shifter pops. With `dirRx`=1 the shifter pushes and the DMA port reads. Data at the read side is valid in the same cycle as the pop.
- R3: With `thrMode`=0 (per-element) the burst length is one word, so each request covers exactly one DMA beat, whatever the threshold holds.
- R4: With `thrMode`=1 the burst length is the threshold field value plus one.
- R5: In transmit, an idle request arms on the clock edge where free space (DEPTH minus occupancy) is at least the burst length, while `enable` is high.
- R6: In receive, an idle request arms on the clock edge where occupancy is at least the burst length, while `enable` is high.
- R7: An armed request drops on the edge that accepts its last DMA beat, after exactly burst-length beats, and is evaluated again on the next edge. In transmit, starting from empty, this keeps requesting until the FIFO is full, and then stays low.
- R8: Transmit uses only `txThresh` and receive uses only `rxThresh`.
- R9: A shifter pop in transmit while the FIFO is empty does nothing to the data and sets `underflow`. The flag stays set until reset.
- R10: A shifter push in receive while the FIFO is full drops the word and sets `overflow`. The flag stays set until reset.
- R11: With `enable` low the request is low from the next edge on, and any burst in progress is abandoned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Allows request generation |
| dirRx | input | 1 | 0 = transmit, 1 = receive |
| thrMode | input | 1 | 0 = per-element, 1 = threshold bursts |
| txThresh | input | log2(DEPTH) | Transmit burst length minus one |
| rxThresh | input | log2(DEPTH) | Receive burst length minus one |
| dmaWrEn | input | 1 | DMA write strobe (transmit) |
| dmaWrData | input | WIDTH | DMA write word |
| dmaRdEn | input | 1 | DMA read strobe (receive) |
| dmaRdData | output | WIDTH | Head-of-FIFO word for the DMA side |
| dmaReq | output | 1 | Request line to the DMA engine |
| serPushEn | input | 1 | Shifter push strobe (receive) |
| serPushData | input | WIDTH | Shifter push word |
| serPopEn | input | 1 | Shifter pop strobe (transmit) |
| serPopData | output | WIDTH | Head-of-FIFO word for the shifter |
| underflow | output | 1 | Sticky: shifter popped while empty |
| overflow | output | 1 | Sticky: shifter pushed while full |

## Verification
A shifter pop and a DMA write can land on the same edge while the FIFO is empty. The pop must then be refused and flag underflow, and the write must still be stored. The bench provokes this by driving both strobes in the same cycle into an empty transmit FIFO. It then checks that `underflow` is set, that `serPopData` shows the written word, and that a later pop consumes it. A second collision happens when the last beat of a burst retires and the request re-arms on the following edge. The bench measures the exact beat count of back-to-back bursts and checks that no request appears once the FIFO is full.

// File: rtl/audFifoPkg.sv
`timescale 1ns/1ps
package audFifoPkg;
  // Strobes from control into the storage datapath
  typedef struct packed {
    logic wrStb;
    logic rdStb;
  } fifoStrobe_t;
endpackage

// File: rtl/audFifoData.sv
`timescale 1ns/1ps
module audFifoData
  import audFifoPkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  fifoStrobe_t      strb,
  input  logic             dirRx,
  input  logic [WIDTH-1:0] dmaWrData,
  input  logic [WIDTH-1:0] serPushData,
  output logic [WIDTH-1:0] headData
);
  localparam int  AW      = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam bit  IS_POW2 = ((DEPTH & (DEPTH - 1)) == 0);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr, wrNext, rdNext;
  logic [WIDTH-1:0] wrWord;

  // Pointer wrap: free-running for power-of-two depths, compare otherwise
  generate
    if (IS_POW2) begin : g_wrapPow2
      assign wrNext = wrPtr + AW'(1);
      assign rdNext = rdPtr + AW'(1);
    end else begin : g_wrapCmp
      assign wrNext = (wrPtr == AW'(DEPTH - 1)) ? '0 : wrPtr + AW'(1);
      assign rdNext = (rdPtr == AW'(DEPTH - 1)) ? '0 : rdPtr + AW'(1);
    end
  endgenerate

  assign wrWord   = dirRx ? serPushData : dmaWrData;
  assign headData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (strb.wrStb) mem[wrPtr] <= wrWord;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strb.wrStb) wrPtr <= wrNext;
      if (strb.rdStb) rdPtr <= rdNext;
    end
  end
endmodule

// File: rtl/audFifoCtrl.sv
`timescale 1ns/1ps
module audFifoCtrl
  import audFifoPkg::*;
#(
  parameter int DEPTH = 1024
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  enable,
  input  logic                                  dirRx,
  input  logic                                  thrMode,
  input  logic [((DEPTH>1)?$clog2(DEPTH):1)-1:0] txThresh,
  input  logic [((DEPTH>1)?$clog2(DEPTH):1)-1:0] rxThresh,
  input  logic                                  dmaWrEn,
  input  logic                                  dmaRdEn,
  input  logic                                  serPushEn,
  input  logic                                  serPopEn,
  output fifoStrobe_t                           strb,
  output logic [$clog2(DEPTH+1)-1:0]            occ,
  output logic                                  dmaReq,
  output logic                                  underflow,
  output logic                                  overflow
);
  localparam int THR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic             pushReq, popReq, wrOk, rdOk, dmaBeat;
  logic             isEmpty, isFull;
  logic [THR_W-1:0] selThr;
  logic [CNT_W-1:0] occQ, burstSize, metric, remainQ;
  logic             activeQ, udfQ, ovfQ;

  always_comb begin
    pushReq   = dirRx ? serPushEn : dmaWrEn;
    popReq    = dirRx ? dmaRdEn   : serPopEn;
    isEmpty   = (occQ == '0);
    isFull    = (occQ == FULL_CNT);
    wrOk      = pushReq && !isFull;
    rdOk      = popReq  && !isEmpty;
    dmaBeat   = dirRx ? rdOk : wrOk;
    selThr    = dirRx ? rxThresh : txThresh;
    burstSize = thrMode ? (CNT_W'(selThr) + CNT_W'(1)) : CNT_W'(1);
    metric    = dirRx ? occQ : (FULL_CNT - occQ);
  end

  // Occupancy
  always_ff @(posedge clk) begin
    if (rst) occQ <= '0;
    else begin
      case ({wrOk, rdOk})
        2'b10:   occQ <= occQ + CNT_W'(1);
        2'b01:   occQ <= occQ - CNT_W'(1);
        default: occQ <= occQ;
      endcase
    end
  end

  // Burst request: arm on whole-burst room/data, retire after burstSize beats
  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      activeQ <= 1'b0;
      remainQ <= '0;
    end else if (activeQ) begin
      if (dmaBeat) begin
        remainQ <= remainQ - CNT_W'(1);
        if (remainQ == CNT_W'(1)) activeQ <= 1'b0;
      end
    end else if (metric >= burstSize) begin
      activeQ <= 1'b1;
      remainQ <= burstSize;
    end
  end

  // Sticky shifter-side error flags
  always_ff @(posedge clk) begin
    if (rst) begin
      udfQ <= 1'b0;
      ovfQ <= 1'b0;
    end else begin
      if (!dirRx && serPopEn && isEmpty) udfQ <= 1'b1;
      if (dirRx && serPushEn && isFull)  ovfQ <= 1'b1;
    end
  end

  assign strb.wrStb = wrOk;
  assign strb.rdStb = rdOk;
  assign occ        = occQ;
  assign dmaReq     = activeQ;
  assign underflow  = udfQ;
  assign overflow   = ovfQ;
endmodule

// File: rtl/audFifoReq.sv
`timescale 1ns/1ps
module audFifoReq
  import audFifoPkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 32
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  enable,
  input  logic                                  dirRx,
  input  logic                                  thrMode,
  input  logic [((DEPTH>1)?$clog2(DEPTH):1)-1:0] txThresh,
  input  logic [((DEPTH>1)?$clog2(DEPTH):1)-1:0] rxThresh,
  input  logic                                  dmaWrEn,
  input  logic [WIDTH-1:0]                      dmaWrData,
  input  logic                                  dmaRdEn,
  output logic [WIDTH-1:0]                      dmaRdData,
  output logic                                  dmaReq,
  input  logic                                  serPushEn,
  input  logic [WIDTH-1:0]                      serPushData,
  input  logic                                  serPopEn,
  output logic [WIDTH-1:0]                      serPopData,
  output logic                                  underflow,
  output logic                                  overflow
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  fifoStrobe_t      strb;
  logic [CNT_W-1:0] occ;
  logic [WIDTH-1:0] headData;

  audFifoCtrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rst(rst), .enable(enable), .dirRx(dirRx), .thrMode(thrMode),
    .txThresh(txThresh), .rxThresh(rxThresh),
    .dmaWrEn(dmaWrEn), .dmaRdEn(dmaRdEn),
    .serPushEn(serPushEn), .serPopEn(serPopEn),
    .strb(strb), .occ(occ), .dmaReq(dmaReq),
    .underflow(underflow), .overflow(overflow)
  );

  audFifoData #(.DEPTH(DEPTH), .WIDTH(WIDTH)) data_i (
    .clk(clk), .rst(rst), .strb(strb), .dirRx(dirRx),
    .dmaWrData(dmaWrData), .serPushData(serPushData),
    .headData(headData)
  );

  assign dmaRdData  = headData;
  assign serPopData = headData;
endmodule

// File: rtl/audFifoReqChk.sv
`timescale 1ns/1ps
module audFifoReqChk #(
  parameter int DEPTH = 1024
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       enable,
  input logic                       dirRx,
  input logic                       serPushEn,
  input logic                       serPopEn,
  input logic                       dmaReq,
  input logic                       underflow,
  input logic                       overflow,
  input logic [$clog2(DEPTH+1)-1:0] occ
);
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!dmaReq && !underflow && !overflow && occ == '0));

  a_r2_occ_bound: assert property (@(posedge clk) disable iff (rst)
    occ <= ($clog2(DEPTH+1))'(DEPTH));

  a_r9_underflow_sticky: assert property (@(posedge clk) disable iff (rst)
    underflow |=> underflow);

  a_r9_underflow_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(underflow) |-> $past(!dirRx && serPopEn));

  a_r10_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  a_r10_overflow_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(overflow) |-> $past(dirRx && serPushEn));

  a_r11_enable_drop: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !dmaReq);
endmodule

bind audFifoReq audFifoReqChk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst(rst), .enable(enable), .dirRx(dirRx),
  .serPushEn(serPushEn), .serPopEn(serPopEn), .dmaReq(dmaReq),
  .underflow(underflow), .overflow(overflow), .occ(occ)
);

// File: tb/audFifoReq_tb_top.sv
`timescale 1ns/1ps
module audFifoReq_tb_top;
  localparam int DEPTH = 16;
  localparam int WIDTH = 32;
  localparam int THR_W = 4;

  logic clk = 1'b0;
  logic rst, enable, dirRx, thrMode;
  logic [THR_W-1:0] txThresh, rxThresh;
  logic dmaWrEn, dmaRdEn, serPushEn, serPopEn;
  logic [WIDTH-1:0] dmaWrData, serPushData, dmaRdData, serPopData;
  logic dmaReq, underflow, overflow;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  audFifoReq #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut_i (
    .clk(clk), .rst(rst), .enable(enable), .dirRx(dirRx), .thrMode(thrMode),
    .txThresh(txThresh), .rxThresh(rxThresh),
    .dmaWrEn(dmaWrEn), .dmaWrData(dmaWrData),
    .dmaRdEn(dmaRdEn), .dmaRdData(dmaRdData), .dmaReq(dmaReq),
    .serPushEn(serPushEn), .serPushData(serPushData),
    .serPopEn(serPopEn), .serPopData(serPopData),
    .underflow(underflow), .overflow(overflow)
  );

  typedef struct packed {
    logic       rx;
    logic       mode;
    logic [3:0] txThr;
    logic [3:0] rxThr;
    logic [4:0] pre;
    logic       expReq;
    logic [4:0] expBurst;
  } vec_t;

  // R3 R4 R5 R6 R8: arming and burst length per configuration
  localparam vec_t VEC [0:8] = '{
    '{1'b0, 1'b0, 4'd7,  4'd15, 5'd0,  1'b1, 5'd1 },
    '{1'b0, 1'b1, 4'd7,  4'd0,  5'd0,  1'b1, 5'd8 },
    '{1'b0, 1'b1, 4'd7,  4'd0,  5'd9,  1'b0, 5'd0 },
    '{1'b0, 1'b1, 4'd7,  4'd0,  5'd8,  1'b1, 5'd8 },
    '{1'b0, 1'b1, 4'd15, 4'd0,  5'd0,  1'b1, 5'd16},
    '{1'b1, 1'b0, 4'd0,  4'd7,  5'd1,  1'b1, 5'd1 },
    '{1'b1, 1'b1, 4'd0,  4'd3,  5'd3,  1'b0, 5'd0 },
    '{1'b1, 1'b1, 4'd15, 4'd3,  5'd4,  1'b1, 5'd4 },
    '{1'b1, 1'b1, 4'd0,  4'd15, 5'd16, 1'b1, 5'd16}
  };

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; enable = 1'b0; dirRx = 1'b0; thrMode = 1'b0;
    txThresh = '0; rxThresh = '0;
    dmaWrEn = 1'b0; dmaRdEn = 1'b0; serPushEn = 1'b0; serPopEn = 1'b0;
    dmaWrData = '0; serPushData = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // Push n words into the side that fills in the current direction
  task automatic preload(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      if (dirRx) begin serPushEn = 1'b1; serPushData = WIDTH'(base + i); end
      else       begin dmaWrEn   = 1'b1; dmaWrData   = WIDTH'(base + i); end
      @(negedge clk);
    end
    serPushEn = 1'b0; dmaWrEn = 1'b0;
  endtask

  // Called at a negedge with dmaReq high: serve beats while the request holds
  task automatic runBurst(output int n);
    n = 0;
    while (dmaReq && n < 64) begin
      if (dirRx) dmaRdEn = 1'b1; else dmaWrEn = 1'b1;
      n++;
      @(negedge clk);
    end
    dmaRdEn = 1'b0; dmaWrEn = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    rst = 1'b1;
    doReset();

    // R1: reset state
    chk("R1 req", dmaReq, 0);
    chk("R1 underflow", underflow, 0);
    chk("R1 overflow", overflow, 0);

    // Vector table
    for (int v = 0; v < 9; v++) begin
      doReset();
      dirRx = VEC[v].rx; thrMode = VEC[v].mode;
      txThresh = VEC[v].txThr; rxThresh = VEC[v].rxThr;
      preload(int'(VEC[v].pre), 0);
      enable = 1'b1;
      @(negedge clk);
      chk(VEC[v].rx ? "R6 R8 arm" : "R5 R8 arm", dmaReq, VEC[v].expReq);
      if (VEC[v].expReq) begin
        runBurst(n);
        chk(VEC[v].mode ? "R4 burst" : "R3 burst", n, VEC[v].expBurst);
      end
    end

    // R7: back-to-back bursts fill an empty transmit FIFO, then stay quiet
    doReset();
    thrMode = 1'b1; txThresh = 4'd7; enable = 1'b1;
    @(negedge clk);
    runBurst(n);
    chk("R7 first burst", n, 8);
    @(negedge clk);
    chk("R7 rearm", dmaReq, 1);
    runBurst(n);
    chk("R7 second burst", n, 8);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R7 full no req", dmaReq, 0);
    end

    // R11: enable low drops the request
    doReset();
    enable = 1'b1;
    @(negedge clk);
    chk("R11 armed", dmaReq, 1);
    enable = 1'b0;
    @(negedge clk);
    chk("R11 dropped", dmaReq, 0);

    // R2: transmit order
    doReset();
    preload(3, 32'h11);
    for (int i = 0; i < 3; i++) begin
      chk("R2 tx order", serPopData, 32'h11 + i);
      serPopEn = 1'b1;
      @(negedge clk);
      serPopEn = 1'b0;
    end

    // R9: pop on empty in the same cycle as a DMA write
    doReset();
    serPopEn = 1'b1; dmaWrEn = 1'b1; dmaWrData = 32'hABCD;
    @(negedge clk);
    serPopEn = 1'b0; dmaWrEn = 1'b0;
    chk("R9 underflow set", underflow, 1);
    chk("R9 overflow clear", overflow, 0);
    chk("R9 write kept", serPopData, 32'hABCD);
    serPopEn = 1'b1;
    @(negedge clk);
    serPopEn = 1'b0;
    @(negedge clk);
    chk("R9 sticky", underflow, 1);

    // R10: overflow drops the extra word; R2 receive order
    doReset();
    dirRx = 1'b1;
    preload(DEPTH, 100);
    chk("R10 no overflow yet", overflow, 0);
    serPushEn = 1'b1; serPushData = 32'd999;
    @(negedge clk);
    serPushEn = 1'b0;
    chk("R10 overflow set", overflow, 1);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R2 R10 rx order", dmaRdData, 100 + i);
      dmaRdEn = 1'b1;
      @(negedge clk);
      dmaRdEn = 1'b0;
    end
    chk("R10 sticky", overflow, 1);
    chk("R9 rx no underflow", underflow, 0);

    // R1: reset clears sticky flags and empties FIFO
    doReset();
    dirRx = 1'b1; enable = 1'b1;
    chk("R1 overflow cleared", overflow, 0);
    @(negedge clk);
    chk("R1 empty no rx req", dmaReq, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule